// File: doc/BRIEF.md
# Two-View Plane Coincidence Trigger

This block builds the top-level trigger decision for a stack of detector planes read out in two orthogonal views. Each plane delivers four strip-coincidence levels per view: at least one, two, three or four neighbouring strip groups firing together. Software picks one level M and a depth N. A view triggers when N adjacent planes all show level M at the same moment. The two view triggers are combined by OR into a single final trigger.

An accepted final trigger raises an attention line toward the host. It also freezes a snapshot of every plane's fold inputs, taken after the input masks, so the host can read them later. Three saturating scalers count view and final triggers. A small register port carries configuration, the scaler and snapshot readback, attention clear and scaler clear.

Top module: `ftrig_top`

## Requirements
- R1: Control register (address 0) field bits [1:0] picks the fold level (0 = one-fold … 3 = four-fold). In an input vector, bit p*4+f carries fold f of plane p.
- R2: Control bits [7:4] set the depth N. A view hits only when N planes in a row, inside the plane range and without wrap-around, show the chosen fold. N = 0 acts as 1, and N larger than the plane count never hits.
- R3: Input mask registers (address 1 for X, address 2 for Y) use the same bit layout as the inputs. A set bit forces that fold input inactive, both for triggering and in the snapshot.
- R4: Each view scaler (X read at address 4, Y at address 5) counts rising edges of its view trigger. Control bit 8 masks the X trigger and bit 9 masks the Y trigger; a masked view neither counts nor feeds the final trigger.
- R5: A rising edge of the OR of the unmasked views produces a one-cycle `final_trig` pulse and raises `attn`. Both appear on the third rising clock edge after the fold inputs change.
- R6: `attn` (also status address 9, bit 0) stays high until a write of bit 0 to the command address 3. While it is high, no final trigger is accepted, pulsed or counted.
- R7: On each accepted final trigger, the masked fold inputs of both views are latched (readable at addresses 7 and 8) and held until the next accepted trigger.
- R8: Control bit 10 masks the final trigger: no pulse, no attention, no count, no snapshot.
- R9: The final-trigger scaler (address 6) counts accepted final triggers. All scalers are SCALER_W bits wide (24 by default), stop at their maximum value, and clear on a write of bit 1 to address 3.
- R10: After reset the control register reads 0x50 (one-fold, depth 5). Masks, scalers, snapshots and `attn` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| x_fold | input | NPLANES*4 | X-view fold signals, bit p*4+f |
| y_fold | input | NPLANES*4 | Y-view fold signals, bit p*4+f |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| final_trig | output | 1 | One-cycle accepted final trigger pulse |
| attn | output | 1 | Attention request, held until cleared |

## Verification
The hardest case to reach is a final trigger that arrives while attention is still pending. Blocking it must leave the snapshot and the final scaler untouched, even though the view scalers keep counting. Random fold patterns are held long enough to cross the pipeline, and the attention clear is issued on only about half of the steps, so view edges often land on a pending request. Directed sequences cover the window edges at the last plane, depths 0 and 15, and enough trigger edges to drive the narrowed bench scalers into saturation.

// File: rtl/ftrig_pkg.sv
package ftrig_pkg;
    localparam int FOLDS   = 4;
    localparam int SEL_W   = 2;
    localparam int DEPTH_W = 4;
    localparam int ADDR_W  = 4;
    localparam int CTRL_W  = 11;

    typedef struct packed {
        logic               mask_fin;
        logic               mask_y;
        logic               mask_x;
        logic [DEPTH_W-1:0] depth;
        logic [1:0]         rsvd;
        logic [SEL_W-1:0]   fold_sel;
    } ctrl_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 4'd0,
        A_XMASK = 4'd1,
        A_YMASK = 4'd2,
        A_CMD   = 4'd3,
        A_SCX   = 4'd4,
        A_SCY   = 4'd5,
        A_SCF   = 4'd6,
        A_LATX  = 4'd7,
        A_LATY  = 4'd8,
        A_STAT  = 4'd9
    } reg_addr_e;

    localparam int CMD_CLR_ATTN = 0;
    localparam int CMD_CLR_SC   = 1;

    localparam ctrl_t CTRL_RESET = '{mask_fin: 1'b0, mask_y: 1'b0, mask_x: 1'b0,
                                     depth: 4'd5, rsvd: 2'b00, fold_sel: 2'd0};

    function automatic logic [DEPTH_W-1:0] eff_depth(input logic [DEPTH_W-1:0] d);
        return (d == '0) ? DEPTH_W'(1) : d;
    endfunction
endpackage

// File: rtl/ftrig_view.sv
module ftrig_view
    import ftrig_pkg::*;
#(
    parameter int NPLANES = 14,
    localparam int NB  = NPLANES * FOLDS,
    localparam int SPW = NPLANES + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NB-1:0]      fold_in,
    input  logic [NB-1:0]      in_mask,
    input  logic [SEL_W-1:0]   fold_sel,
    input  logic [DEPTH_W-1:0] depth,
    output logic [NB-1:0]      fold_seen,
    output logic               hit
);
    logic [NB-1:0]      fold_q;
    logic [NPLANES-1:0] active;
    logic [NPLANES-1:0] win_ok;
    logic [DEPTH_W-1:0] d_eff;
    logic [SPW-1:0]     ones_d;
    logic [SPW-1:0]     act_ext;

    always_ff @(posedge clk) begin
        if (rst) fold_q <= '0;
        else     fold_q <= fold_in & ~in_mask;
    end

    always_comb begin
        for (int p = 0; p < NPLANES; p++)
            active[p] = fold_q[p*FOLDS + int'(fold_sel)];
    end

    assign d_eff   = eff_depth(depth);
    assign ones_d  = (SPW'(1) << d_eff) - SPW'(1);
    assign act_ext = {1'b0, active};

    for (genvar w = 0; w < NPLANES; w++) begin : g_win
        logic [SPW-1:0] span;
        assign span      = ones_d << w;
        assign win_ok[w] = ((int'(d_eff) + w) <= NPLANES) && ((act_ext & span) == span);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit       <= 1'b0;
            fold_seen <= '0;
        end else begin
            hit       <= |win_ok;
            fold_seen <= fold_q;
        end
    end
endmodule

// File: rtl/ftrig_scaler.sv
module ftrig_scaler #(
    parameter int W = 24,
    localparam logic [W-1:0] MAXV = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr)               count <= '0;
        else if (inc && count != MAXV) count <= count + W'(1);
    end
endmodule

// File: rtl/ftrig_top.sv
module ftrig_top
    import ftrig_pkg::*;
#(
    parameter int NPLANES  = 14,
    parameter int SCALER_W = 24,
    parameter int DATA_W   = 64,
    localparam int NB      = NPLANES * FOLDS,
    localparam int NVIEW   = 2,
    localparam int NSC     = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB-1:0]     x_fold,
    input  logic [NB-1:0]     y_fold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              final_trig,
    output logic              attn
);
    ctrl_t              ctrl_q;
    logic [NB-1:0]      in_mask_q [NVIEW];
    logic [NB-1:0]      fold_in   [NVIEW];
    logic [NB-1:0]      fold_seen [NVIEW];
    logic [NB-1:0]      lat_q     [NVIEW];
    logic [NVIEW-1:0]   view_hit, view_out, view_prev, view_edge, out_mask;
    logic               any_prev, fire, attn_q;
    logic               clr_attn, clr_sc;
    logic [NSC-1:0]     sc_inc;
    logic [SCALER_W-1:0] sc_val [NSC];
    logic [NB-1:0]      lat_x, lat_y;
    logic [SCALER_W-1:0] sc_fin, sc_x;
    logic               mask_fin_w;

    assign fold_in[0] = x_fold;
    assign fold_in[1] = y_fold;

    // configuration and command decode
    assign clr_attn = wr_en && (reg_addr_e'(wr_addr) == A_CMD) && wr_data[CMD_CLR_ATTN];
    assign clr_sc   = wr_en && (reg_addr_e'(wr_addr) == A_CMD) && wr_data[CMD_CLR_SC];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= CTRL_RESET;
            in_mask_q[0] <= '0;
            in_mask_q[1] <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_CTRL: begin
                    ctrl_q      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                    ctrl_q.rsvd <= '0;
                end
                A_XMASK: in_mask_q[0] <= wr_data[NB-1:0];
                A_YMASK: in_mask_q[1] <= wr_data[NB-1:0];
                default: ;
            endcase
        end
    end

    // per-view window coincidence
    for (genvar v = 0; v < NVIEW; v++) begin : g_view
        ftrig_view #(.NPLANES(NPLANES)) u_view (
            .clk      (clk),
            .rst      (rst),
            .fold_in  (fold_in[v]),
            .in_mask  (in_mask_q[v]),
            .fold_sel (ctrl_q.fold_sel),
            .depth    (ctrl_q.depth),
            .fold_seen(fold_seen[v]),
            .hit      (view_hit[v])
        );
    end

    // output masks, edge detection, final decision
    assign out_mask  = {ctrl_q.mask_y, ctrl_q.mask_x};
    assign view_out  = view_hit & ~out_mask;
    assign view_edge = view_out & ~view_prev;
    assign fire      = (|view_out) && !any_prev && !attn_q && !ctrl_q.mask_fin;

    always_ff @(posedge clk) begin
        if (rst) begin
            view_prev  <= '0;
            any_prev   <= 1'b0;
            attn_q     <= 1'b0;
            final_trig <= 1'b0;
            lat_q[0]   <= '0;
            lat_q[1]   <= '0;
        end else begin
            view_prev  <= view_out;
            any_prev   <= |view_out;
            final_trig <= fire;
            if (fire)          attn_q <= 1'b1;
            else if (clr_attn) attn_q <= 1'b0;
            if (fire) begin
                lat_q[0] <= fold_seen[0];
                lat_q[1] <= fold_seen[1];
            end
        end
    end
    assign attn = attn_q;

    // scalers: X edges, Y edges, accepted finals
    assign sc_inc = {fire, view_edge[1], view_edge[0]};
    for (genvar s = 0; s < NSC; s++) begin : g_sc
        ftrig_scaler #(.W(SCALER_W)) u_sc (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr_sc),
            .inc  (sc_inc[s]),
            .count(sc_val[s])
        );
    end

    assign lat_x      = lat_q[0];
    assign lat_y      = lat_q[1];
    assign sc_fin     = sc_val[2];
    assign sc_x       = sc_val[0];
    assign mask_fin_w = ctrl_q.mask_fin;

    // read mux
    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            A_CTRL:  rd_data = DATA_W'(ctrl_q);
            A_XMASK: rd_data = DATA_W'(in_mask_q[0]);
            A_YMASK: rd_data = DATA_W'(in_mask_q[1]);
            A_SCX:   rd_data = DATA_W'(sc_val[0]);
            A_SCY:   rd_data = DATA_W'(sc_val[1]);
            A_SCF:   rd_data = DATA_W'(sc_val[2]);
            A_LATX:  rd_data = DATA_W'(lat_q[0]);
            A_LATY:  rd_data = DATA_W'(lat_q[1]);
            A_STAT:  rd_data = DATA_W'(attn_q);
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/ftrig_chk.sv
module ftrig_chk #(
    parameter int SCALER_W = 24,
    parameter int NB       = 56
) (
    input logic                clk,
    input logic                rst,
    input logic                final_trig,
    input logic                attn,
    input logic                clr_attn,
    input logic                clr_sc,
    input logic                mask_fin,
    input logic [SCALER_W-1:0] sc_fin,
    input logic [SCALER_W-1:0] sc_x,
    input logic [NB-1:0]       lat_x,
    input logic [NB-1:0]       lat_y
);
    localparam logic [SCALER_W-1:0] MAXV = {SCALER_W{1'b1}};

    assert_attn_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (attn && !clr_attn) |=> attn);
    assert_no_pulse_pending_R6: assert property (@(posedge clk) disable iff (rst)
        attn |=> !final_trig);
    assert_pulse_sets_attn_R5: assert property (@(posedge clk) disable iff (rst)
        final_trig |-> attn);
    assert_attn_rise_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(attn) |-> final_trig);
    assert_final_masked_R8: assert property (@(posedge clk) disable iff (rst)
        mask_fin |=> !final_trig);
    assert_snapshot_stable_R7: assert property (@(posedge clk) disable iff (rst)
        attn |=> ($stable(lat_x) && $stable(lat_y)));
    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (sc_fin == MAXV && !clr_sc) |=> sc_fin == MAXV);
    assert_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
        !clr_sc |=> sc_x >= $past(sc_x));
endmodule

bind ftrig_top ftrig_chk #(.SCALER_W(SCALER_W), .NB(NB)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .final_trig(final_trig),
    .attn      (attn),
    .clr_attn  (clr_attn),
    .clr_sc    (clr_sc),
    .mask_fin  (mask_fin_w),
    .sc_fin    (sc_fin),
    .sc_x      (sc_x),
    .lat_x     (lat_x),
    .lat_y     (lat_y)
);

// File: tb/ftrig_top_test.sv
module ftrig_top_test;
    localparam int NP   = 14;
    localparam int NB   = NP * 4;
    localparam int SW   = 6;
    localparam int MAXC = (1 << SW) - 1;

    logic        clk = 1'b0;
    logic        rst;
    logic [NB-1:0] x_fold, y_fold;
    logic        wr_en;
    logic [3:0]  wr_addr, rd_addr;
    logic [63:0] wr_data;
    logic [63:0] rd_data;
    logic        final_trig, attn;

    int tests = 0, fails = 0, pulses = 0;

    // model state
    int sel_m, dep_m;
    logic [NB-1:0] xm_m, ym_m, latx_m, laty_m;
    bit omx, omy, omf, prev_x, prev_y, prev_any, attn_m;
    int scx_m, scy_m, scf_m, fires_m;

    ftrig_top #(.NPLANES(NP), .SCALER_W(SW), .DATA_W(64)) uut (
        .clk(clk), .rst(rst), .x_fold(x_fold), .y_fold(y_fold),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .final_trig(final_trig), .attn(attn)
    );

    always #5 clk = ~clk;

    always @(negedge clk) if (!rst && final_trig) pulses++;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        summary();
    end

    task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit mhit(logic [NB-1:0] f, logic [NB-1:0] m, int sel, int depth);
        logic [NB-1:0] g = f & ~m;
        int d = (depth == 0) ? 1 : depth;
        for (int s = 0; s + d <= NP; s++) begin
            bit ok = 1;
            for (int k = 0; k < d; k++) if (!g[(s+k)*4 + sel]) ok = 0;
            if (ok) return 1;
        end
        return 0;
    endfunction

    task automatic wr(logic [3:0] a, logic [63:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [63:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(string req);
        logic [63:0] v;
        rd(4'd4, v); chk(req, "x scaler", v, scx_m);
        rd(4'd5, v); chk(req, "y scaler", v, scy_m);
        rd(4'd6, v); chk(req, "final scaler", v, scf_m);
        rd(4'd7, v); chk(req, "x snapshot", v, latx_m);
        rd(4'd8, v); chk(req, "y snapshot", v, laty_m);
        rd(4'd9, v); chk(req, "status attn", v, attn_m);
        chk(req, "attn pin", attn, attn_m);
        chk(req, "pulse count", pulses, fires_m);
    endtask

    task automatic step(logic [NB-1:0] xv, logic [NB-1:0] yv, string req);
        bit xh, yh, any, fire;
        @(negedge clk);
        x_fold = xv; y_fold = yv;
        repeat (4) @(negedge clk);
        xh = mhit(xv, xm_m, sel_m, dep_m) && !omx;
        yh = mhit(yv, ym_m, sel_m, dep_m) && !omy;
        any = xh || yh;
        fire = any && !prev_any && !attn_m && !omf;
        if (xh && !prev_x && scx_m < MAXC) scx_m++;
        if (yh && !prev_y && scy_m < MAXC) scy_m++;
        if (fire) begin
            if (scf_m < MAXC) scf_m++;
            fires_m++;
            attn_m = 1;
            latx_m = xv & ~xm_m;
            laty_m = yv & ~ym_m;
        end
        prev_x = xh; prev_y = yh; prev_any = any;
        check_all(req);
    endtask

    task automatic clear_attn();
        wr(4'd3, 64'h1);
        attn_m = 0;
    endtask

    task automatic cfg(int sel, int dep, logic [NB-1:0] xm, logic [NB-1:0] ym,
                       bit mx, bit my, bit mf);
        step('0, '0, "R1");
        wr(4'd0, 64'(sel) | (64'(dep) << 4) | (64'(mx) << 8) | (64'(my) << 9) | (64'(mf) << 10));
        wr(4'd1, 64'(xm));
        wr(4'd2, 64'(ym));
        sel_m = sel; dep_m = dep; xm_m = xm; ym_m = ym; omx = mx; omy = my; omf = mf;
    endtask

    function automatic logic [NB-1:0] planes(int sel, int lo, int hi);
        logic [NB-1:0] r = '0;
        for (int p = lo; p <= hi; p++) r[p*4 + sel] = 1'b1;
        return r;
    endfunction

    function automatic logic [NB-1:0] rnd_fold();
        logic [NB-1:0] r;
        for (int i = 0; i < NB; i++) r[i] = (($urandom % 4) != 0);
        return r;
    endfunction

    initial begin
        logic [63:0] v;
        int unsigned seed;
        seed = $urandom(32'd20071215);
        rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        x_fold = '0; y_fold = '0;
        sel_m = 0; dep_m = 5; xm_m = '0; ym_m = '0; omx = 0; omy = 0; omf = 0;
        prev_x = 0; prev_y = 0; prev_any = 0; attn_m = 0;
        scx_m = 0; scy_m = 0; scf_m = 0; fires_m = 0; latx_m = '0; laty_m = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R10 reset state
        rd(4'd0, v); chk("R10", "ctrl reset", v, 64'h50);
        rd(4'd1, v); chk("R10", "x mask reset", v, 0);
        rd(4'd2, v); chk("R10", "y mask reset", v, 0);
        check_all("R10");

        // R5 latency: pulse on third edge after the inputs change
        @(negedge clk);
        x_fold = planes(0, 2, 6);
        repeat (2) @(negedge clk);
        chk("R5", "no pulse after two edges", final_trig, 0);
        @(negedge clk);
        chk("R5", "pulse on third edge", final_trig, 1);
        @(negedge clk);
        chk("R5", "pulse lasts one cycle", final_trig, 0);
        scx_m = 1; scf_m = 1; fires_m = 1; attn_m = 1; prev_x = 1; prev_any = 1;
        latx_m = planes(0, 2, 6);
        check_all("R5");
        clear_attn();
        step('0, '0, "R6");

        // R6 blocked while pending
        step(planes(0, 0, 4), '0, "R6");
        step('0, '0, "R6");
        step('0, planes(0, 9, 13), "R6");
        clear_attn();
        step('0, '0, "R6");

        // R2 window edges, no wrap
        cfg(0, 3, '0, '0, 0, 0, 0);
        step(planes(0, 12, 13) | planes(0, 0, 0), '0, "R2");
        step(planes(0, 11, 13), '0, "R2");
        clear_attn();
        cfg(0, 0, '0, '0, 0, 0, 0);
        step('0, planes(0, 7, 7), "R2");
        clear_attn();
        cfg(3, 15, '0, '0, 0, 0, 0);
        step({NB{1'b1}}, {NB{1'b1}}, "R2");

        // R1 fold level selection
        cfg(2, 3, '0, '0, 0, 0, 0);
        step(planes(1, 4, 6), '0, "R1");
        step(planes(2, 4, 6), '0, "R1");
        clear_attn();

        // R3 input masks
        cfg(1, 4, planes(1, 5, 5), '0, 0, 0, 0);
        step(planes(1, 3, 6), '0, "R3");
        step(planes(1, 6, 9) | planes(1, 5, 5), '0, "R3");
        clear_attn();

        // R4 view output masks
        cfg(0, 2, '0, '0, 1, 0, 0);
        step(planes(0, 0, 1), '0, "R4");
        step(planes(0, 0, 1), planes(0, 0, 1), "R4");
        clear_attn();

        // R8 final mask
        cfg(0, 2, '0, '0, 0, 0, 1);
        step(planes(0, 3, 4), '0, "R8");
        step('0, '0, "R8");

        // R9 saturation and clear
        cfg(0, 1, '0, '0, 0, 1, 0);
        for (int i = 0; i < 70; i++) begin
            step(planes(0, 8, 8), '0, "R9");
            clear_attn();
            step('0, '0, "R9");
        end
        wr(4'd3, 64'h2);
        scx_m = 0; scy_m = 0; scf_m = 0;
        check_all("R9");

        // random mix, R7 snapshots under pending attention
        for (int blk = 0; blk < 8; blk++) begin
            int pair = $urandom % 4;
            logic [NB-1:0] mx = '0, my = '0;
            mx[$urandom % NB] = 1'b1;
            my[$urandom % NB] = 1'b1;
            cfg(pair, 5 - pair, mx, my, 0, 0, 0);
            for (int i = 0; i < 20; i++) begin
                step(rnd_fold(), rnd_fold(), "R7");
                if ($urandom % 2) clear_attn();
            end
        end

        summary();
    end
endmodule